// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits behind the receive bit recovery of an Ethernet port and decides, frame by frame, what went wrong. One bit arrives per clock while `rx_valid` is high; a frame lasts from its first qualified bit until `rx_valid` drops. Bits of each octet arrive least significant first. The block counts whole octets and leftover bits and runs a serial CRC-32 over the stream. It keeps the CRC verdict of the most recent octet boundary, compares the octet count against a programmable ceiling, and watches a strobe from the receive FIFO that signals an overrun.

When a frame closes, the block registers a four-bit status word, a babbling-receive flag, a truncation marker and the stored byte count, and pulses `done` for one cycle. Those outputs stay put until the next frame begins. The descriptor logic copies them into the frame's closing descriptor. Software may disregard a CRC verdict, but the check itself always runs.

Top module: `rx_err_classifier`

## Requirements
- R1: While reset is active, and after it releases, `done`, `rx_status`, `babble`, `trunc` and `byte_cnt` read zero until the first frame closes.
- R2: A frame opens on the first cycle `rx_valid` is high and closes on the first cycle it is low again. `done` is high for exactly the one cycle after that closing cycle, and the outputs hold the frame's results from that cycle on.
- R3: The CRC is CRC-32 with generator 0x04C11DB7 and a seed of all ones, fed in wire order. A frame whose whole octets, FCS included, leave the residue 0xC704DD7B at its last octet boundary, and which ends on an octet boundary, reports `rx_status` = 0.
- R4: A frame that ends on an octet boundary with a wrong residue sets the CRC error bit, `rx_status[2]`, and never sets the non-octet bit in the same frame.
- R5: A frame that ends 1 to 7 bits past an octet boundary is judged on the residue at that boundary. A wrong residue sets the non-octet bit, `rx_status[1]`, and leaves `rx_status[2]` clear. A correct residue reports no CRC-related error. A frame with no whole octet counts as a wrong residue.
- R6: When the count of whole octets is strictly greater than `max_len`, both the long-frame bit `rx_status[3]` and `babble` are set. A count equal to `max_len` sets neither.
- R7: `byte_cnt` reports the whole-octet count, capped at 2**BC_W-1. When the count exceeds that cap, `trunc` is set. The `max_len` comparison uses the uncapped count.
- R8: An `fifo_ovr` pulse during an open frame closes it at once. The bit presented in that cycle is not taken, `done` pulses on the next cycle, and `rx_status[0]` is set while bits 1 and 2 are cleared. `byte_cnt` holds the octets completed before the overrun. Further bits are ignored, with no further `done`, until `rx_valid` goes low.
- R9: After `done`, the outputs keep their values until the next frame opens. On the cycle after a frame opens they read zero until that frame closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Frame qualifier, high for every bit of a frame |
| rx_bit | input | 1 | Serial data bit, octets sent least significant bit first |
| fifo_ovr | input | 1 | Receive FIFO overrun strobe |
| max_len | input | CNT_W | Largest octet count accepted without a long-frame error |
| done | output | 1 | One-cycle pulse when a frame's results are ready |
| rx_status | output | 4 | bit0 overrun, bit1 non-octet, bit2 CRC, bit3 long frame |
| babble | output | 1 | Babbling-receive interrupt flag |
| trunc | output | 1 | Frame held more octets than can be stored |
| byte_cnt | output | BC_W | Stored octet count, capped at 2**BC_W-1 |

## Verification
The bench builds the block with BC_W = 8 and CNT_W = 12. With these values the storage cap drops to 255 octets, so truncation can be reached with a frame of a few hundred octets. The wider counter still keeps the length comparison above the cap honest, since `max_len` can be set both beyond and below the cap in the same test. The default BC_W = 11 would need frames several thousand octets long to reach the cap, and the random frames, dribble bits and overrun positions, kept short, would not come close to it.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  // packed order puts ov at bit 0 and lg at bit 3
  typedef struct packed {
    logic lg;
    logic cr;
    logic no;
    logic ov;
  } rx_stat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;

  // one serial LFSR step, data bit taken in wire order
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    crc_step = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? CRC_POLY : 32'h0);
  endfunction

endpackage

// File: rtl/rxc_ctrl.sv
module rxc_ctrl
  import rxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic fifo_ovr,
  output logic start,
  output logic accept,
  output logic close,
  output logic close_ov,
  output logic fresh
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    start    = 1'b0;
    accept   = 1'b0;
    close    = 1'b0;
    close_ov = 1'b0;
    fresh    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rx_valid) begin
          if (fifo_ovr) begin
            close    = 1'b1;
            close_ov = 1'b1;
            fresh    = 1'b1;
            state_d  = ST_DROP;
          end else begin
            start   = 1'b1;
            accept  = 1'b1;
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (!rx_valid) begin
          close   = 1'b1;
          state_d = ST_IDLE;
        end else if (fifo_ovr) begin
          close    = 1'b1;
          close_ov = 1'b1;
          state_d  = ST_DROP;
        end else begin
          accept = 1'b1;
        end
      end
      ST_DROP: begin
        if (!rx_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: after an overrun nothing is taken or closed until the carrier drops
  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> (!accept && !close));

  // R2: a close always leaves the receiving state
  assert_close_exits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (state_q != ST_RECV));

endmodule

// File: rtl/rxc_len.sv
module rxc_len #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             accept,
  output logic [2:0]       bit_cnt,
  output logic [CNT_W-1:0] octets,
  output logic             octet_done
);

  localparam logic [CNT_W-1:0] OCT_TOP = {CNT_W{1'b1}};

  logic [2:0]       bit_d;
  logic [CNT_W-1:0] oct_d;
  logic             cnt_en;

  assign octet_done = accept && !start && (bit_cnt == 3'd7);
  assign cnt_en     = start || accept;

  always_comb begin
    bit_d = bit_cnt;
    oct_d = octets;
    if (start) begin
      bit_d = 3'd1;
      oct_d = '0;
    end else if (accept) begin
      bit_d = bit_cnt + 3'd1;
      if (octet_done && (octets != OCT_TOP)) oct_d = octets + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      octets  <= '0;
    end else if (cnt_en) begin
      bit_cnt <= bit_d;
      octets  <= oct_d;
    end
  end

  // R7: the full count never goes back within a frame
  assert_oct_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start) |=> (octets >= $past(octets)));

  // R2: the first bit of a frame leaves one bit pending and no octet
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bit_cnt == 3'd1 && octets == '0));

endmodule

// File: rtl/rxc_crc.sv
module rxc_crc
  import rxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic accept,
  input  logic octet_done,
  input  logic rx_bit,
  output logic crc_ok
);

  logic [31:0] crc_q, crc_d, crc_nx;
  logic        ok_d;
  logic        crc_en;

  assign crc_nx = crc_step(start ? CRC_SEED : crc_q, rx_bit);
  assign crc_en = start || accept;

  always_comb begin
    crc_d = crc_nx;
    ok_d  = crc_ok;
    if (start)           ok_d = 1'b0;
    else if (octet_done) ok_d = (crc_nx == CRC_RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= CRC_SEED;
      crc_ok <= 1'b0;
    end else if (crc_en) begin
      crc_q  <= crc_d;
      crc_ok <= ok_d;
    end
  end

  // R5: a frame with no whole octet yet has no passing CRC verdict
  assert_empty_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !crc_ok);

  // R5: the verdict only moves on octet boundaries or at frame start
  assert_verdict_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !octet_done) |=> $stable(crc_ok));

endmodule

// File: rtl/rx_err_classifier.sv
module rx_err_classifier
  import rxc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BC_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             fifo_ovr,
  input  logic [CNT_W-1:0] max_len,
  output logic             done,
  output logic [3:0]       rx_status,
  output logic             babble,
  output logic             trunc,
  output logic [BC_W-1:0]  byte_cnt
);

  localparam logic [CNT_W-1:0] STORE_MAX = CNT_W'((2 ** BC_W) - 1);
  localparam logic [BC_W-1:0]  BC_MAX    = {BC_W{1'b1}};

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic             start, accept, close, close_ov, fresh;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] octets;
  logic             octet_done;
  logic             crc_ok;

  rxc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .rx_valid (rx_valid),
    .fifo_ovr (fifo_ovr),
    .start    (start),
    .accept   (accept),
    .close    (close),
    .close_ov (close_ov),
    .fresh    (fresh)
  );

  rxc_len #(.CNT_W(CNT_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_i),
    .start      (start),
    .accept     (accept),
    .bit_cnt    (bit_cnt),
    .octets     (octets),
    .octet_done (octet_done)
  );

  rxc_crc u_crc (
    .clk        (clk),
    .rst_n      (rst_i),
    .start      (start),
    .accept     (accept),
    .octet_done (octet_done),
    .rx_bit     (rx_bit),
    .crc_ok     (crc_ok)
  );

  // end-of-frame classification
  logic [CNT_W-1:0] eff_oct;
  logic             dribble;
  rx_stat_t         stat_nx, stat_d, stat_q;
  logic             trunc_nx, trunc_d, trunc_q;
  logic [BC_W-1:0]  bc_nx, bc_d, bc_q;
  logic             done_d, done_q;
  logic             stat_en;

  always_comb begin
    eff_oct    = fresh ? '0 : octets;
    dribble    = !fresh && (bit_cnt != 3'd0);
    stat_nx.ov = close_ov;
    stat_nx.no = !close_ov && dribble && !crc_ok;
    stat_nx.cr = !close_ov && !dribble && !crc_ok;
    stat_nx.lg = (eff_oct > max_len);
    trunc_nx   = (eff_oct > STORE_MAX);
    bc_nx      = trunc_nx ? BC_MAX : eff_oct[BC_W-1:0];
  end

  always_comb begin
    stat_en = close || start;
    done_d  = close;
    stat_d  = stat_q;
    trunc_d = trunc_q;
    bc_d    = bc_q;
    if (close) begin
      stat_d  = stat_nx;
      trunc_d = trunc_nx;
      bc_d    = bc_nx;
    end else if (start) begin
      stat_d  = '0;
      trunc_d = 1'b0;
      bc_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stat_q  <= '0;
      trunc_q <= 1'b0;
      bc_q    <= '0;
    end else if (stat_en) begin
      stat_q  <= stat_d;
      trunc_q <= trunc_d;
      bc_q    <= bc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done      = done_q;
  assign rx_status = stat_q;
  assign babble    = stat_q.lg;
  assign trunc     = trunc_q;
  assign byte_cnt  = bc_q;

  // R8: an overrun masks both CRC-related bits
  assert_ov_wins_R8: assert property (@(posedge clk) disable iff (!rst_i)
    stat_q.ov |-> (!stat_q.no && !stat_q.cr));

  // R4: CRC error and non-octet error never share a frame
  assert_no_cr_excl_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !(stat_q.no && stat_q.cr));

  // R7: a truncated frame reports the capped count
  assert_trunc_cap_R7: assert property (@(posedge clk) disable iff (!rst_i)
    trunc_q |-> (bc_q == BC_MAX));

  // R9: results hold between a close and the next frame start
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (!close && !start) |=> ($stable(stat_q) && $stable(bc_q) && $stable(trunc_q)));

endmodule

// File: tb/test_rx_err_classifier.sv
`timescale 1ns/1ps
module test_rx_err_classifier;

  localparam int CNT_W = 12;
  localparam int BC_W  = 8;
  localparam int CAP   = (1 << BC_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic             rx_bit = 1'b0;
  logic             fifo_ovr = 1'b0;
  logic [CNT_W-1:0] max_len = '0;
  logic             done;
  logic [3:0]       rx_status;
  logic             babble;
  logic             trunc;
  logic [BC_W-1:0]  byte_cnt;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [7:0] fr [0:399];
  logic       drib [0:7];

  always #2.5 clk = ~clk;

  rx_err_classifier #(.CNT_W(CNT_W), .BC_W(BC_W)) i_rx_err_classifier (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .fifo_ovr(fifo_ovr), .max_len(max_len), .done(done),
    .rx_status(rx_status), .babble(babble), .trunc(trunc), .byte_cnt(byte_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reflected CRC-32 over n stored bytes
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ fr[i][k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  // payload of plen random bytes plus FCS, optional single bit flip
  task automatic build(input int plen, input bit corrupt);
    logic [31:0] f;
    int p;
    for (int i = 0; i < plen; i++) fr[i] = 8'($urandom);
    f = ~ref_crc(plen);
    for (int k = 0; k < 4; k++) fr[plen + k] = f[8*k +: 8];
    if (corrupt) begin
      p = $urandom_range(plen * 8 + 31, 0);
      fr[p / 8][p % 8] = ~fr[p / 8][p % 8];
    end
    for (int k = 0; k < 8; k++) drib[k] = 1'($urandom);
  endtask

  function automatic logic get_bit(input int i, input int nb);
    if (i < nb * 8) return fr[i / 8][i % 8];
    return drib[i - nb * 8];
  endfunction

  // nb whole octets, nd trailing bits, overrun at bit index ob (-1: none, ob <= total-2)
  task automatic run_frame(input int nb, input int nd, input int ob, input int mlen);
    int tb_bits = nb * 8 + nd;
    int oct;
    bit good;
    logic [3:0] es;
    bit etr;
    int ebc;
    max_len = CNT_W'(mlen);
    oct  = (ob >= 0) ? ob / 8 : nb;
    good = (nb > 0) && (ref_crc(nb) == 32'hDEBB20E3);
    es[0] = (ob >= 0);
    es[1] = (ob < 0) && (nd != 0) && !good;
    es[2] = (ob < 0) && (nd == 0) && !good;
    es[3] = (oct > mlen);
    etr   = (oct > CAP);
    ebc   = etr ? CAP : oct;
    for (int i = 0; i < tb_bits; i++) begin
      @(negedge clk);
      if (i == 1 && ob != 0) begin
        chk("R9", "status cleared after start", int'(rx_status), 0);
        chk("R9", "count cleared after start", int'(byte_cnt), 0);
      end
      if (ob >= 0 && i == ob + 1) begin
        chk("R8", "done after overrun", int'(done), 1);
        chk("R8", "status on overrun", int'(rx_status), int'(es));
        chk("R8", "count on overrun", int'(byte_cnt), ebc);
      end
      if (ob >= 0 && i == ob + 2)
        chk("R8", "single done on overrun", int'(done), 0);
      rx_valid = 1'b1;
      rx_bit   = get_bit(i, nb);
      fifo_ovr = (i == ob);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    fifo_ovr = 1'b0;
    @(negedge clk);
    if (ob >= 0) begin
      chk("R8", "no done for ignored tail", int'(done), 0);
    end else begin
      chk("R2", "done after close", int'(done), 1);
      chk(nd != 0 ? "R5" : (good ? "R3" : "R4"), "crc class", int'(rx_status[2:0]), int'(es[2:0]));
      chk("R6", "long bit", int'(rx_status[3]), int'(es[3]));
      chk("R6", "babble", int'(babble), int'(es[3]));
      chk("R7", "byte count", int'(byte_cnt), ebc);
      chk("R7", "trunc", int'(trunc), int'(etr));
    end
    @(negedge clk);
    chk("R2", "done is one cycle", int'(done), 0);
    chk("R9", "status held", int'(rx_status), int'(es));
    chk("R9", "count held", int'(byte_cnt), ebc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "status in reset", int'(rx_status), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "status after reset", int'(rx_status), 0);
    chk("R1", "count after reset", int'(byte_cnt), 0);
    chk("R1", "flags after reset", int'({done, babble, trunc}), 0);

    build(20, 0); run_frame(24, 0, -1, 100);   // R3 clean
    build(20, 1); run_frame(24, 0, -1, 100);   // R4 bad CRC
    build(16, 0); run_frame(20, 5, -1, 100);   // R5 dribble, good
    build(16, 1); run_frame(20, 7, -1, 100);   // R5 dribble, bad
    build(0, 0);  run_frame(0, 3, -1, 100);    // R5 no whole octet
    build(10, 0); run_frame(14, 0, -1, 14);    // R6 equal: no long
    build(10, 0); run_frame(14, 0, -1, 13);    // R6 exceed
    build(296, 0); run_frame(300, 0, -1, 400); // R7 truncated, not long
    build(296, 1); run_frame(300, 2, -1, 299); // R7 truncated and long
    build(12, 1); run_frame(16, 0, 0, 100);    // R8 overrun on first bit
    build(12, 1); run_frame(16, 3, 45, 100);   // R8 mid frame, bad CRC masked
    build(12, 0); run_frame(16, 0, 126, 3);    // R8 with long

    for (int n = 0; n < 40; n++) begin
      int pl = $urandom_range(40, 0);
      int nd = ($urandom_range(1, 0) == 1) ? $urandom_range(7, 1) : 0;
      int tbits = (pl + 4) * 8 + nd;
      int ob = ($urandom_range(4, 0) == 0) ? $urandom_range(tbits - 2, 0) : -1;
      build(pl, $urandom_range(1, 0) == 1);
      run_frame(pl + 4, nd, ob, $urandom_range(50, 2));
    end
    finish_run();
  end

endmodule